// File: doc/BRIEF.md
# ECC Error Capture Log Register

This block is the status register a memory controller keeps for errors found by its ECC checker on read data. Each read transfer that the checker flags arrives as one report: whether the error was correctable or uncorrectable, plus the bank, rank, chunk and syndrome of the transfer. The block keeps a sticky status flag for each error class. It keeps an overflow flag for each class that records a further error of that class arriving while its status flag is still set. It also holds the location and syndrome of the error that was logged, and software reads all of this as one 32-bit word.

Software clears flags by writing ones to them. A pulse from the global error-status register clears only the two overflow flags. The captured location stays frozen while an error is logged, and only a more severe error may replace it. A syndrome of all ones marks data that arrived poisoned, as opposed to a decoded bit error. The block keeps that value unchanged.

The report input is a valid/ready stream. `err_ready` is held high at all times, so the block never applies back-pressure and a report is taken in every cycle where `err_valid` is high. The register port and the clear pulse are plain control pins.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, `reg_rdata` reads all zeros.
- R2: A correctable report (`err_uncorr`=0) with no flag set sets bit 0. In the same edge it loads bank into bits 31:29, rank into 28:27, chunk into 26:24 and syndrome into 23:16. All of this is visible in the cycle after the report.
- R3: A correctable report while bit 0 is already set sets bit 1 and leaves bit 0 set.
- R4: An uncorrectable report (`err_uncorr`=1) sets bit 2.
- R5: An uncorrectable report while bit 2 is already set sets bit 3.
- R6: A write to the register clears each of bits 3:0 whose `reg_wdata` bit is 1. A flag whose `reg_wdata` bit is 0 keeps its value.
- R7: A `glb_ovf_clr` pulse clears bits 1 and 3 and leaves bits 0 and 2 unchanged.
- R8: While bit 0 or bit 2 is set, a correctable report does not change bits 31:16. After both status bits are clear, the next report loads those bits again.
- R9: An uncorrectable report while bit 2 is clear loads bits 31:16, even when bit 0 is set. A correctable report never replaces fields that an uncorrectable report loaded.
- R10: When a report sets a flag in the same cycle that a write-one or the clear pulse would clear that flag, the flag is set.
- R11: A syndrome of 8'hFF (poisoned data) is loaded and read back unchanged. Bits 15:4 always read zero. Register writes never change bits 31:16.
- R12: `err_ready` is 1 in every cycle after reset, and every report with `err_valid`=1 is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error report present this cycle |
| err_ready | output | 1 | Report accepted; held high |
| err_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_bank | input | BANK_W | Bank of the failing read |
| err_rank | input | RANK_W | Rank of the failing read |
| err_chunk | input | CHUNK_W | Chunk number of the failing read |
| err_synd | input | SYND_W | Syndrome; all ones = poisoned |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; bits 3:0 are write-one-to-clear |
| reg_rdata | output | 32 | Register contents |
| glb_ovf_clr | input | 1 | Pulse that clears both overflow flags |

## Verification
The bench builds the block with its default widths: 3 bank bits, 2 rank bits, 3 chunk bits and 8 syndrome bits. These fill bits 31:16 exactly, so the packing of every field and the 12 reserved zero bits sit in the word the bench compares. The directed sequences and a stretch of pseudo-random traffic reach the points where the flags interact. These are: a second error of a class, an uncorrectable error on top of a correctable one, a report colliding with a write-one-to-clear or with the clear pulse, and recapture after both status bits clear. The syndrome value 8'hFF is one of the reachable cases.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_W  = 32;
  localparam int FLAG_W = 4;

  typedef enum logic {
    CLS_CE = 1'b0,
    CLS_UE = 1'b1
  } err_cls_e;

  localparam int NUM_CLS = 2;
endpackage

// File: rtl/ecc_flag_pair.sv
module ecc_flag_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_sts,
  input  logic clr_ovf,
  input  logic glb_clr,
  output logic sts_o,
  output logic ovf_o
);
  logic sts_q, ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      // a new error beats any clear in the same cycle
      if (hit)          sts_q <= 1'b1;
      else if (clr_sts) sts_q <= 1'b0;

      if (hit && sts_q)            ovf_q <= 1'b1;
      else if (clr_ovf || glb_clr) ovf_q <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign ovf_o = ovf_q;

  // R10
  hit_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts_o);

  // R3
  repeat_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sts_o) |=> ovf_o);

  // R6
  w1c_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sts && !hit) |=> !sts_o);

  // R7
  glb_clr_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_clr && !(hit && sts_o)) |=> !ovf_o);
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] din,
  output logic [FIELD_W-1:0] dout
);
  logic [FIELD_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= din;
  end

  assign dout = hold_q;

  // R2
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(din)));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int RANK_W  = 2,
  parameter int CHUNK_W = 3,
  parameter int SYND_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_valid,
  output logic               err_ready,
  input  logic               err_uncorr,
  input  logic [BANK_W-1:0]  err_bank,
  input  logic [RANK_W-1:0]  err_rank,
  input  logic [CHUNK_W-1:0] err_chunk,
  input  logic [SYND_W-1:0]  err_synd,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               glb_ovf_clr
);
  localparam int FIELD_W = BANK_W + RANK_W + CHUNK_W + SYND_W;
  localparam int RSV_W   = REG_W - FLAG_W - FIELD_W;

  logic               take;
  logic [NUM_CLS-1:0] cls_hit, cls_sts, cls_ovf;
  logic               load;
  logic [FIELD_W-1:0] fields;
  logic [FLAG_W-1:0]  flags;
  logic               unused_wdata;

  assign err_ready = 1'b1;
  assign take      = err_valid && err_ready;

  assign cls_hit[int'(CLS_CE)] = take && !err_uncorr;
  assign cls_hit[int'(CLS_UE)] = take &&  err_uncorr;

  // flag bit 2*c is status, 2*c+1 is overflow for class c
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    ecc_flag_pair u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (cls_hit[c]),
      .clr_sts (reg_we && reg_wdata[2*c]),
      .clr_ovf (reg_we && reg_wdata[2*c+1]),
      .glb_clr (glb_ovf_clr),
      .sts_o   (cls_sts[c]),
      .ovf_o   (cls_ovf[c])
    );
    assign flags[2*c]   = cls_sts[c];
    assign flags[2*c+1] = cls_ovf[c];
  end

  // uncorrectable may replace correctable fields; never the reverse
  assign load = (cls_hit[int'(CLS_UE)] && !cls_sts[int'(CLS_UE)]) ||
                (cls_hit[int'(CLS_CE)] && !(|cls_sts));

  ecc_capture #(.FIELD_W(FIELD_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   ({err_bank, err_rank, err_chunk, err_synd}),
    .dout  (fields)
  );

  if (RSV_W > 0) begin : g_pad
    assign reg_rdata = {fields, {RSV_W{1'b0}}, flags};
  end else begin : g_nopad
    assign reg_rdata = {fields, flags};
  end

  assign unused_wdata = ^reg_wdata[31:FLAG_W];

  // R8
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cls_sts) && !(cls_hit[int'(CLS_UE)] && !cls_sts[int'(CLS_UE)]))
      |=> $stable(reg_rdata[31:REG_W-FIELD_W]));

  // R9
  ue_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && err_uncorr && !reg_rdata[2])
      |=> (reg_rdata[REG_W-1 -: FIELD_W] ==
           $past({err_bank, err_rank, err_chunk, err_synd})));

  // R12
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ready);
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_uncorr = 1'b0;
  logic [2:0]  err_bank = '0;
  logic [1:0]  err_rank = '0;
  logic [2:0]  err_chunk = '0;
  logic [7:0]  err_synd = '0;
  logic        reg_we = 1'b0, glb_ovf_clr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_ready;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  bit m_ce, m_cov, m_ue, m_uov;
  int m_bank, m_rank, m_chunk, m_synd;
  int unsigned lfsr = 32'h1ACE5EED;

  always #4 clk = ~clk;  // 125 MHz

  ecc_err_log u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_uncorr(err_uncorr), .err_bank(err_bank), .err_rank(err_rank),
    .err_chunk(err_chunk), .err_synd(err_synd), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glb_ovf_clr(glb_ovf_clr)
  );

  function automatic logic [31:0] expect_word();
    logic [31:0] w;
    w = '0;
    w[31:29] = 3'(m_bank);
    w[28:27] = 2'(m_rank);
    w[26:24] = 3'(m_chunk);
    w[23:16] = 8'(m_synd);
    w[3] = m_uov; w[2] = m_ue; w[1] = m_cov; w[0] = m_ce;
    return w;
  endfunction

  task automatic compare(input string tag);
    tests++;
    if (reg_rdata !== expect_word() || err_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s rdata=%h ready=%b expected rdata=%h ready=1",
               tag, reg_rdata, err_ready, expect_word());
    end
  endtask

  // drive at negedge, advance model over the coming posedge, check at next negedge
  task automatic step(input string tag, input bit v, input bit ue,
                      input int bank, input int rank, input int chunk, input int synd,
                      input bit we, input logic [31:0] wd, input bit gclr);
    bit ce_hit, ue_hit, cap;
    err_valid = v; err_uncorr = ue;
    err_bank = 3'(bank); err_rank = 2'(rank); err_chunk = 3'(chunk); err_synd = 8'(synd);
    reg_we = we; reg_wdata = wd; glb_ovf_clr = gclr;
    ce_hit = v && !ue;
    ue_hit = v && ue;
    cap = (ue_hit && !m_ue) || (ce_hit && !m_ce && !m_ue);
    if (cap) begin m_bank = bank; m_rank = rank; m_chunk = chunk; m_synd = synd; end
    if (ce_hit && m_ce) m_cov = 1; else if ((we && wd[1]) || gclr) m_cov = 0;
    if (ue_hit && m_ue) m_uov = 1; else if ((we && wd[3]) || gclr) m_uov = 0;
    if (ce_hit) m_ce = 1; else if (we && wd[0]) m_ce = 0;
    if (ue_hit) m_ue = 1; else if (we && wd[2]) m_ue = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_ce = 0; m_cov = 0; m_ue = 0; m_uov = 0;
    m_bank = 0; m_rank = 0; m_chunk = 0; m_synd = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: first correctable error captured
    step("R2", 1, 0, 5, 2, 3, 8'h21, 0, 0, 0);
    idle("R2");
    // R3: second correctable error -> overflow, fields kept
    step("R3", 1, 0, 1, 1, 1, 8'h44, 0, 0, 0);
    // R6: clear overflow only, then status
    step("R6", 0, 0, 0, 0, 0, 0, 1, 32'h2, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 32'h0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 32'h1, 0);
    // R4 / R11: poisoned uncorrectable
    step("R4", 1, 1, 6, 3, 7, 8'hFF, 0, 0, 0);
    // R9: correctable cannot replace uncorrectable fields
    step("R9", 1, 0, 2, 0, 4, 8'h11, 0, 0, 0);
    // R5
    step("R5", 1, 1, 3, 1, 2, 8'h99, 0, 0, 0);
    // R7: global pulse clears overflows only
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R11: full write does not move fields, reserved zero
    step("R11", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFF0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 32'hF, 0);
    // R8: recapture after both clear
    step("R8", 1, 0, 7, 3, 0, 8'h5A, 0, 0, 0);
    // R10: set collides with write-one-to-clear
    step("R10", 1, 0, 1, 0, 1, 8'h02, 1, 32'h3, 0);
    step("R10", 1, 0, 1, 0, 1, 8'h03, 0, 0, 1);
    // R9: uncorrectable replaces correctable fields
    step("R9", 1, 1, 4, 2, 6, 8'hC3, 0, 0, 0);
    step("R10", 1, 1, 0, 0, 0, 8'h01, 1, 32'hC, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 32'hF, 0);
    // R12 / R8: pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      step("R8", lfsr[31:30] != 2'b00, lfsr[29], int'(lfsr[28:26]), int'(lfsr[25:24]),
           int'(lfsr[23:21]), (lfsr[20:18] == 3'd0) ? 8'hFF : int'(lfsr[15:8]),
           lfsr[17:16] == 2'b11, {28'(lfsr), lfsr[7:4]}, lfsr[3:0] == 4'hF);
    end
    idle("R12");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule